// File: doc/BRIEF.md
# Position Compare and Home Capture Unit

This block sits beside an external quadrature position counter. It watches the signed count that the counter produces and drives one compare pin. The pin is set from a low limit, a high limit and a two-bit mode. The pin can be off, can flag counts at or above the high limit, can flag counts at or below the low limit, or can flag counts outside the window between the two limits. The compare result is registered, so the pin follows the count one clock later.

The block also takes a conditioned home signal. Polarity and filtering are handled upstream. When either of two capture enables is set, a rising edge on that signal stores the current count in a capture register. A single-cycle event pulse marks each new capture. Both enables and the mode reset to zero, so after reset the pin is low and nothing is captured.

Top module: `pos_cmp_cap`

## Requirements
- R1: During and right after reset, `cmp_out`, `cap_pulse` and `cap_val` are all zero.
- R2: With `cmp_mode` = 2'b00, `cmp_out` is held low whatever the count and limits are.
- R3: With `cmp_mode` = 2'b01, `cmp_out` is high exactly when the count, read as signed two's complement, is greater than or equal to `hi_lim`.
- R4: With `cmp_mode` = 2'b10, `cmp_out` is high exactly when the signed count is less than or equal to `lo_lim`.
- R5: With `cmp_mode` = 2'b11, `cmp_out` is high when the signed count is at or below `lo_lim`, or at or above `hi_lim`.
- R6: `cmp_out` is registered. A change of count, limits or mode shows on the pin after the next rising clock edge, and not before it.
- R7: When `home_cap_en` = 1, a rising edge of `home_in` captures the count into `cap_val`.
- R8: When `cap_en` = 1, a rising edge of `home_in` captures the count even if `home_cap_en` = 0.
- R9: When both enables are 0, home edges cause no capture, `cap_pulse` stays low and `cap_val` keeps its value.
- R10: A capture raises `cap_pulse` for exactly one clock, on the edge after the cycle in which the rising home edge is seen. In that same cycle, `cap_val` holds the count that was present in the edge cycle.
- R11: Holding `home_in` high gives one capture only. A new capture needs the signal to go low and rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pos_cnt | input | CNT_W | Signed position count from the counter |
| home_in | input | 1 | Conditioned home signal |
| lo_lim | input | CNT_W | Signed low compare limit |
| hi_lim | input | CNT_W | Signed high compare limit |
| cmp_mode | input | 2 | Compare mode: 00 off, 01 high limit, 10 low limit, 11 outside window |
| home_cap_en | input | 1 | Home capture enable |
| cap_en | input | 1 | Second capture enable |
| cmp_out | output | 1 | Registered compare pin |
| cap_val | output | CNT_W | Captured position value |
| cap_pulse | output | 1 | One-clock capture event |

## Verification
The assertions check the following on every cycle:
- for each mode, that the pin value matches the signed comparison of the previous cycle;
- that the capture pulse never lasts longer than one clock;
- that the captured value equals the count from the edge cycle;
- that the capture register holds its value whenever no pulse is present;
- that home edges with both enables clear never produce a pulse.

Some behaviour only the bench scenarios can show:
- the sign-sensitive corners: values equal to a limit, the most negative and most positive counts, and negative limits;
- that the pin does not move before the clock edge;
- that a home level held high across many cycles yields a single capture.

// File: rtl/pos_cmp_cap.sv
module pos_cmp_cap #(
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [CNT_W-1:0] pos_cnt,
  input  logic                    home_in,
  input  logic signed [CNT_W-1:0] lo_lim,
  input  logic signed [CNT_W-1:0] hi_lim,
  input  logic [1:0]              cmp_mode,
  input  logic                    home_cap_en,
  input  logic                    cap_en,
  output logic                    cmp_out,
  output logic signed [CNT_W-1:0] cap_val,
  output logic                    cap_pulse
);

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_HI  = 2'b01;
  localparam logic [1:0] MODE_LO  = 2'b10;
  localparam logic [1:0] MODE_WIN = 2'b11;

  logic at_hi, at_lo, cmp_next;
  logic home_q, home_rise, cap_go;

  assign at_hi = (pos_cnt >= hi_lim);
  assign at_lo = (pos_cnt <= lo_lim);

  always_comb begin
    unique case (cmp_mode)
      MODE_HI:  cmp_next = at_hi;
      MODE_LO:  cmp_next = at_lo;
      MODE_WIN: cmp_next = at_hi | at_lo;
      default:  cmp_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_out <= 1'b0;
    else        cmp_out <= cmp_next;
  end

  assign home_rise = home_in & ~home_q;
  assign cap_go    = home_rise & (home_cap_en | cap_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      home_q    <= 1'b0;
      cap_pulse <= 1'b0;
      cap_val   <= '0;
    end else begin
      home_q    <= home_in;
      cap_pulse <= cap_go;
      if (cap_go) cap_val <= pos_cnt;
    end
  end

  p_mode_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mode == MODE_OFF |=> !cmp_out);

  p_mode_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mode == MODE_HI |=> cmp_out == ($past(pos_cnt) >= $past(hi_lim)));

  p_mode_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mode == MODE_LO |=> cmp_out == ($past(pos_cnt) <= $past(lo_lim)));

  p_mode_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_mode == MODE_WIN |=>
      cmp_out == (($past(pos_cnt) >= $past(hi_lim)) || ($past(pos_cnt) <= $past(lo_lim))));

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |=> !cap_pulse);

  p_cap_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> cap_val == $past(pos_cnt));

  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_pulse |-> $stable(cap_val));

  p_no_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(home_in) && !home_cap_en && !cap_en) |=> !cap_pulse);

endmodule

// File: tb/pos_cmp_cap_tb.sv
module pos_cmp_cap_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [31:0] pos_cnt = '0, lo_lim = '0, hi_lim = '0;
  logic home_in = 1'b0, home_cap_en = 1'b0, cap_en = 1'b0;
  logic [1:0] cmp_mode = 2'b00;
  logic cmp_out, cap_pulse;
  logic signed [31:0] cap_val;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pos_cmp_cap #(.CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .pos_cnt(pos_cnt), .home_in(home_in),
    .lo_lim(lo_lim), .hi_lim(hi_lim), .cmp_mode(cmp_mode),
    .home_cap_en(home_cap_en), .cap_en(cap_en),
    .cmp_out(cmp_out), .cap_val(cap_val), .cap_pulse(cap_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic want(input logic [1:0] m, input logic signed [31:0] c,
                                input logic signed [31:0] lo, input logic signed [31:0] hi);
    case (m)
      2'b01:   return c >= hi;
      2'b10:   return c <= lo;
      2'b11:   return (c >= hi) || (c <= lo);
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    chk("R1 cmp_out", {31'b0, cmp_out}, 32'd0);
    chk("R1 cap_pulse", {31'b0, cap_pulse}, 32'd0);
    chk("R1 cap_val", cap_val, 32'd0);
  endtask

  task automatic t_sweep(input logic [1:0] m, input string req);
    logic signed [31:0] pts [8];
    pts = '{-32'sd101, -32'sd100, -32'sd99, 32'sd0, 32'sd199, 32'sd200,
            32'sh7FFFFFFF, 32'sh80000000};
    lo_lim = -32'sd100; hi_lim = 32'sd200; cmp_mode = m;
    foreach (pts[i]) begin
      pos_cnt = pts[i];
      step();
      chk(req, {31'b0, cmp_out}, {31'b0, want(m, pts[i], lo_lim, hi_lim)});
    end
  endtask

  task automatic t_latency();
    cmp_mode = 2'b01; hi_lim = 32'sd50; pos_cnt = 32'sd0;
    step();
    chk("R6 settled low", {31'b0, cmp_out}, 32'd0);
    pos_cnt = 32'sd60;
    #1 chk("R6 no change before edge", {31'b0, cmp_out}, 32'd0);
    step();
    chk("R6 change after edge", {31'b0, cmp_out}, 32'd1);
    cmp_mode = 2'b00;
    #1 chk("R6 mode change waits", {31'b0, cmp_out}, 32'd1);
    step();
    chk("R2 mode off after edge", {31'b0, cmp_out}, 32'd0);
  endtask

  task automatic t_capture(input logic hce, input logic ce, input logic signed [31:0] v,
                           input string req);
    home_cap_en = hce; cap_en = ce; pos_cnt = v; home_in = 1'b1;
    step();
    chk({req, " pulse"}, {31'b0, cap_pulse}, 32'd1);
    chk({req, " value"}, cap_val, v);
    pos_cnt = v + 32'sd7;
    step();
    chk("R10 pulse one clock", {31'b0, cap_pulse}, 32'd0);
    chk("R11 held high no recapture", cap_val, v);
    step();
    chk("R11 still one capture", {31'b0, cap_pulse}, 32'd0);
    home_in = 1'b0;
    step();
    chk("R10 fall no pulse", {31'b0, cap_pulse}, 32'd0);
  endtask

  task automatic t_disabled();
    logic signed [31:0] old;
    old = cap_val;
    home_cap_en = 1'b0; cap_en = 1'b0; pos_cnt = 32'sd999; home_in = 1'b1;
    step();
    chk("R9 no pulse", {31'b0, cap_pulse}, 32'd0);
    chk("R9 value kept", cap_val, old);
    home_in = 1'b0;
    step();
  endtask

  initial begin
    #400_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_sweep(2'b00, "R2");
    t_sweep(2'b01, "R3");
    t_sweep(2'b10, "R4");
    t_sweep(2'b11, "R5");
    t_latency();
    t_capture(1'b1, 1'b0, -32'sd12345, "R7");
    t_capture(1'b0, 1'b1, 32'sh7FFFFFF0, "R8");
    t_disabled();
    t_capture(1'b1, 1'b1, 32'sd42, "R10");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule